// File: doc/BRIEF.md
# Paged Virtual-to-Physical Address Translator

This block turns a 16-bit program address into a 22-bit memory address. The upper three bits of the program address pick one of eight pages. The lower thirteen bits are the offset inside that page. Every page has an address register, which holds the page base in 64-byte units, and a descriptor, which holds the page length, the growth direction and the access rights. A separate set of page registers exists for each combination of processor mode (kernel, supervisor, user) and access kind (instruction fetch or data). In total there are 48 address registers and 48 descriptors.

Translation is combinational: the physical address and the abort flag follow the inputs in the same cycle. The state is registered. This covers the page registers and four control registers. The first control register holds the relocation enable and the sticky fault flags. The second and third record the page and the address of the first fault. The fourth selects 22-bit or 18-bit physical addressing. Software programs all of them through a simple synchronous write port with a combinational read port. With relocation off, the block applies no mapping: the top 8 KB of program space goes to the top 8 KB of physical space, and every other address is zero-extended.

Top module: `vmap_xlate`

## Requirements
- R1: After reset every page register and control register reads zero, relocation is off, and 18-bit mode is selected.
- R2: With relocation off (control 0 bit 0 = 0), `abort` stays low. A `va` with bits [15:13] = 111 maps to `{9'h1FF, va[12:0]}`. Any other `va` is zero-extended.
- R3: With relocation on and control 3 bit 0 = 1, `pa` = (address register << 6) + `va[12:0]`, kept to 22 bits.
- R4: With relocation on and control 3 bit 0 = 0, the same sum is cut to 18 bits, and `pa[21:18]` is zero.
- R5: The register used depends on `cpu_mode` (00 kernel, 01 supervisor, 11 user), on `is_data` (0 instruction, 1 data) and on `va[15:13]`. Page registers sit at `cfg_addr[7]=0`, with fields [6] descriptor/address, [5:4] mode code, [3] space and [2:0] page.
- R6: With relocation on, a valid access with `cpu_mode` = 10 aborts and sets control 0 bit 13.
- R7: Descriptor bits [1:0] give the access rights: 00 none, 01 read only, 10 none, 11 read/write. A denied valid access aborts and sets control 0 bit 15.
- R8: Descriptor bits [14:8] hold a length in 64-byte blocks, and bit 3 selects downward growth. The block number is `va[12:6]`. When growing upward, a block above the length aborts. When growing downward, a block below the length aborts. Either case sets control 0 bit 14.
- R9: Fault flags in control 0 bits [15:13] are set only by a valid aborting access. They stay set until control 0 is written, and such a write takes priority over a fault in the same cycle. When the flags were all clear, the fault also loads control 1 with {write[6], space[5], mode[4:3], page[2:0]} and loads control 2 with `va`.
- R10: Only the following bits can be written: control 0 bits 15:13 and 0, control 3 bit 0, and descriptor bits 14:8, 3 and 1:0. Control 1 and 2 are read-only. Control registers sit at `cfg_addr` 0x80 to 0x83. Addresses with mode code 10, and addresses 0x84 to 0xFF, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| va | input | 16 | Virtual address |
| cpu_mode | input | 2 | Current processor mode |
| is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| is_write | input | 1 | 1 = write access |
| acc_valid | input | 1 | An access is presented this cycle |
| pa | output | 22 | Physical address |
| abort | output | 1 | Access refused |

## Verification
The assertions assume the translation inputs stay steady around each clock edge. They also assume software does not write control 0 in the same cycle as an aborting access when the capture of control 1 and 2 is under check. The bench changes `va`, `cpu_mode`, `is_data`, `is_write` and `acc_valid` only on falling edges, and it never issues a register write in the same cycle as an access. It draws the mode code 10 only rarely, so that most random accesses exercise the descriptor checks.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int VA_W       = 16;
  localparam int DATA_W     = 16;
  localparam int PAR_SHIFT  = 6;
  localparam int PA_W       = DATA_W + PAR_SHIFT;
  localparam int PA_NARROW  = 18;
  localparam int PAGE_W     = 3;
  localparam int PAGES      = 1 << PAGE_W;
  localparam int OFF_W      = VA_W - PAGE_W;
  localparam int BLK_W      = OFF_W - PAR_SHIFT;
  localparam int MODE_N     = 3;
  localparam int SPACE_N    = 2;
  localparam int SLOTS      = MODE_N * SPACE_N * PAGES;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int ERR_W      = 3;
  localparam int INFO_W     = 3 + 2 + PAGE_W - 1;

  typedef enum logic [1:0] {
    MODE_KERN = 2'b00,
    MODE_SUP  = 2'b01,
    MODE_BAD  = 2'b10,
    MODE_USER = 2'b11
  } mode_e;

  typedef struct packed {
    logic [BLK_W-1:0] plen;
    logic             down;
    logic [1:0]       acf;
  } pdr_t;

  function automatic logic mode_legal(input logic [1:0] m);
    return m != MODE_BAD;
  endfunction

  function automatic logic [1:0] mode_index(input logic [1:0] m);
    case (m)
      MODE_SUP:  return 2'd1;
      MODE_USER: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [1:0] m,
                                                input logic sp,
                                                input logic [PAGE_W-1:0] pg);
    return SLOT_W'(mode_index(m)) * SLOT_W'(SPACE_N * PAGES)
         + SLOT_W'(sp) * SLOT_W'(PAGES) + SLOT_W'(pg);
  endfunction

  function automatic pdr_t pdr_unpack(input logic [DATA_W-1:0] d);
    pdr_t p;
    p.plen = d[8 +: BLK_W];
    p.down = d[3];
    p.acf  = d[1:0];
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] pdr_pack(input pdr_t p);
    return {1'b0, p.plen, 4'b0000, p.down, 1'b0, p.acf};
  endfunction

  // relocated address: base in 64-byte units plus page offset
  function automatic logic [PA_W-1:0] reloc_addr(input logic [DATA_W-1:0] par,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic wide);
    logic [PA_W-1:0] s;
    s = {par, {PAR_SHIFT{1'b0}}} + {{(PA_W-OFF_W){1'b0}}, off};
    if (!wide) s[PA_W-1:PA_NARROW] = '0;
    return s;
  endfunction

  // unmapped address: top page lands on the top of physical space
  function automatic logic [PA_W-1:0] pass_addr(input logic [VA_W-1:0] v);
    if (&v[VA_W-1:OFF_W]) return {{(PA_W-OFF_W){1'b1}}, v[OFF_W-1:0]};
    return {{(PA_W-VA_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/vmap_pagebank.sv
module vmap_pagebank
  import vmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_pdr,
  input  logic [1:0]        wr_mode,
  input  logic              wr_space,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        lk_mode,
  input  logic              lk_space,
  input  logic [PAGE_W-1:0] lk_page,
  output logic [DATA_W-1:0] lk_par,
  output pdr_t              lk_pdr,
  input  logic              rd_pdr,
  input  logic [1:0]        rd_mode,
  input  logic              rd_space,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] par_q [SLOTS];
  pdr_t              pdr_q [SLOTS];
  logic              wr_ok;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] lk_slot;
  logic [SLOT_W-1:0] rd_slot;

  assign wr_ok   = wr_en && mode_legal(wr_mode);
  assign wr_slot = slot_of(wr_mode, wr_space, wr_page);
  assign lk_slot = slot_of(lk_mode, lk_space, lk_page);
  assign rd_slot = slot_of(rd_mode, rd_space, rd_page);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        par_q[g] <= '0;
        pdr_q[g] <= '0;
      end else if (wr_ok && wr_slot == SLOT_W'(g)) begin
        if (wr_pdr) pdr_q[g] <= pdr_unpack(wr_data);
        else        par_q[g] <= wr_data;
      end
    end
  end

  assign lk_par = par_q[lk_slot];
  assign lk_pdr = pdr_q[lk_slot];

  always_comb begin
    if (!mode_legal(rd_mode)) rd_data = '0;
    else if (rd_pdr)          rd_data = pdr_pack(pdr_q[rd_slot]);
    else                      rd_data = par_q[rd_slot];
  end
endmodule

// File: rtl/vmap_check.sv
module vmap_check
  import vmap_pkg::*;
(
  input  pdr_t             pdr,
  input  logic [BLK_W-1:0] blk,
  input  logic             is_write,
  input  logic [1:0]       mode,
  output logic             deny,
  output logic             len_err,
  output logic             mode_err
);
  logic rights_bad;
  logic past_end;

  always_comb begin
    case (pdr.acf)
      2'b11:   rights_bad = 1'b0;
      2'b01:   rights_bad = is_write;
      default: rights_bad = 1'b1;
    endcase
  end

  assign past_end = pdr.down ? (blk < pdr.plen) : (blk > pdr.plen);
  assign mode_err = !mode_legal(mode);
  assign deny     = !mode_err && rights_bad;
  assign len_err  = !mode_err && past_end;
endmodule

// File: rtl/vmap_ctrl.sv
module vmap_ctrl
  import vmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fault,
  input  logic [ERR_W-1:0]  flt_bits,
  input  logic [VA_W-1:0]   flt_va,
  input  logic [INFO_W-1:0] flt_info,
  output logic [DATA_W-1:0] sr0,
  output logic [DATA_W-1:0] sr1,
  output logic [DATA_W-1:0] sr2,
  output logic [DATA_W-1:0] sr3,
  output logic              reloc_on,
  output logic              wide_on
);
  logic [ERR_W-1:0]  err_q;
  logic              en_q;
  logic              wide_q;
  logic [INFO_W-1:0] info_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_sr0;
  logic              wr_sr3;
  logic              capture;
  logic              unused_ok;

  assign wr_sr0  = wr_en && wr_idx == 2'd0;
  assign wr_sr3  = wr_en && wr_idx == 2'd3;
  assign capture = fault && !wr_sr0 && err_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      info_q <= '0;
      va_q   <= '0;
    end else begin
      if (wr_sr0) begin
        err_q <= wr_data[DATA_W-1 -: ERR_W];
        en_q  <= wr_data[0];
      end else if (fault) begin
        err_q <= err_q | flt_bits;
      end
      if (wr_sr3) wide_q <= wr_data[0];
      if (capture) begin
        info_q <= flt_info;
        va_q   <= flt_va;
      end
    end
  end

  assign sr0      = {err_q, {(DATA_W-ERR_W-1){1'b0}}, en_q};
  assign sr1      = {{(DATA_W-INFO_W){1'b0}}, info_q};
  assign sr2      = va_q;
  assign sr3      = {{(DATA_W-1){1'b0}}, wide_q};
  assign reloc_on = en_q;
  assign wide_on  = wide_q;
  assign unused_ok = ^wr_data[DATA_W-ERR_W-1:1];

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_sr0) |-> ((err_q & $past(err_q)) == $past(err_q)));

  // R9
  first_fault_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (va_q == $past(flt_va)));

  // R9
  no_fault_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !wr_sr0) |=> $stable(err_q));
endmodule

// File: rtl/vmap_xlate.sv
module vmap_xlate
  import vmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        cpu_mode,
  input  logic              is_data,
  input  logic              is_write,
  input  logic              acc_valid,
  output logic [PA_W-1:0]   pa,
  output logic              abort
);
  logic              sel_page;
  logic              sel_ctrl;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] sr0, sr1, sr2, sr3;
  logic              reloc_on;
  logic              wide_on;
  logic [DATA_W-1:0] lk_par;
  pdr_t              lk_pdr;
  logic              deny, len_err, mode_err;
  logic [ERR_W-1:0]  why;
  logic              fault;
  logic [INFO_W-1:0] info;
  logic [PA_W-1:0]   pa_reloc;
  logic [PA_W-1:0]   pa_pass;

  assign sel_page = !cfg_addr[7];
  assign sel_ctrl = cfg_addr[7] && cfg_addr[6:2] == '0;

  vmap_pagebank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && sel_page),
    .wr_pdr   (cfg_addr[6]),
    .wr_mode  (cfg_addr[5:4]),
    .wr_space (cfg_addr[3]),
    .wr_page  (cfg_addr[2:0]),
    .wr_data  (cfg_wdata),
    .lk_mode  (cpu_mode),
    .lk_space (is_data),
    .lk_page  (va[VA_W-1:OFF_W]),
    .lk_par   (lk_par),
    .lk_pdr   (lk_pdr),
    .rd_pdr   (cfg_addr[6]),
    .rd_mode  (cfg_addr[5:4]),
    .rd_space (cfg_addr[3]),
    .rd_page  (cfg_addr[2:0]),
    .rd_data  (bank_rd)
  );

  vmap_check u_check (
    .pdr      (lk_pdr),
    .blk      (va[OFF_W-1:PAR_SHIFT]),
    .is_write (is_write),
    .mode     (cpu_mode),
    .deny     (deny),
    .len_err  (len_err),
    .mode_err (mode_err)
  );

  assign why   = reloc_on ? {deny, len_err, mode_err} : '0;
  assign abort = acc_valid && why != '0;
  assign fault = abort;
  assign info  = {is_write, is_data, cpu_mode, va[VA_W-1:OFF_W]};

  vmap_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && sel_ctrl),
    .wr_idx   (cfg_addr[1:0]),
    .wr_data  (cfg_wdata),
    .fault    (fault),
    .flt_bits (why),
    .flt_va   (va),
    .flt_info (info),
    .sr0      (sr0),
    .sr1      (sr1),
    .sr2      (sr2),
    .sr3      (sr3),
    .reloc_on (reloc_on),
    .wide_on  (wide_on)
  );

  assign pa_reloc = reloc_addr(lk_par, va[OFF_W-1:0], wide_on);
  assign pa_pass  = pass_addr(va);
  assign pa       = reloc_on ? pa_reloc : pa_pass;

  always_comb begin
    if (sel_page) cfg_rdata = bank_rd;
    else if (!sel_ctrl) cfg_rdata = '0;
    else begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = sr0;
        2'd1:    cfg_rdata = sr1;
        2'd2:    cfg_rdata = sr2;
        default: cfg_rdata = sr3;
      endcase
    end
  end

  // R2
  off_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reloc_on |-> !abort);

  // R2
  off_io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reloc_on && &va[VA_W-1:OFF_W]) |-> (&pa[PA_W-1:OFF_W]));

  // R3
  low_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_on |-> (pa[PAR_SHIFT-1:0] == va[PAR_SHIFT-1:0]));

  // R4
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_on && !wide_on) |-> (pa[PA_W-1:PA_NARROW] == '0));

  // R6
  bad_mode_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && reloc_on && cpu_mode == MODE_BAD) |-> (abort && !deny && !len_err));

  // R7
  no_rights_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && reloc_on && !mode_err && lk_pdr.acf == 2'b00) |-> abort);

  // R9
  idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !abort);
endmodule

// File: tb/vmap_xlate_tb.sv
`timescale 1ns/1ps
module vmap_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] va = '0;
  logic [1:0]  cpu_mode = '0;
  logic        is_data = 1'b0;
  logic        is_write = 1'b0;
  logic        acc_valid = 1'b0;
  logic [21:0] pa;
  logic        abort;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] m_par [3][2][8];
  logic [15:0] m_pdr [3][2][8];
  logic [2:0]  m_err;
  logic        m_en, m_wide;
  logic [6:0]  m_info;
  logic [15:0] m_va;

  always #5 clk = ~clk;

  vmap_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .va(va), .cpu_mode(cpu_mode),
    .is_data(is_data), .is_write(is_write), .acc_valid(acc_valid),
    .pa(pa), .abort(abort)
  );

  function automatic int midx(input logic [1:0] m);
    return (m == 2'b01) ? 1 : (m == 2'b11) ? 2 : 0;
  endfunction

  function automatic logic [15:0] m_rd(input logic [7:0] a);
    if (!a[7]) begin
      if (a[5:4] == 2'b10) return 16'h0;
      return a[6] ? m_pdr[midx(a[5:4])][a[3]][a[2:0]] : m_par[midx(a[5:4])][a[3]][a[2:0]];
    end
    if (a[6:2] != 0) return 16'h0;
    case (a[1:0])
      2'd0:    return {m_err, 12'h0, m_en};
      2'd1:    return {9'h0, m_info};
      2'd2:    return m_va;
      default: return {15'h0, m_wide};
    endcase
  endfunction

  function automatic logic [2:0] m_why(input logic [15:0] v, input logic [1:0] m,
                                       input logic sp, input logic w);
    logic [15:0] d;
    logic dn, rf, lf;
    int pl, bk;
    if (!m_en) return 3'b000;
    if (m == 2'b10) return 3'b001;
    d  = m_pdr[midx(m)][sp][v[15:13]];
    pl = int'(d[14:8]);
    dn = d[3];
    bk = int'(v[12:6]);
    rf = (d[1:0] == 2'b00) || (d[1:0] == 2'b10) || (d[1:0] == 2'b01 && w);
    lf = dn ? (bk < pl) : (bk > pl);
    return {rf, lf, 1'b0};
  endfunction

  function automatic logic [21:0] m_pa(input logic [15:0] v, input logic [1:0] m,
                                       input logic sp);
    logic [21:0] s;
    if (!m_en) return (v[15:13] == 3'b111) ? {9'h1FF, v[12:0]} : {6'h0, v};
    s = {m_par[midx(m)][sp][v[15:13]], 6'h0} + {9'h0, v[12:0]};
    if (!m_wide) s[21:18] = 4'h0;
    return s;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (!a[7]) begin
      if (a[5:4] != 2'b10) begin
        if (a[6]) m_pdr[midx(a[5:4])][a[3]][a[2:0]] = d & 16'h7F0B;
        else      m_par[midx(a[5:4])][a[3]][a[2:0]] = d;
      end
    end else if (a[6:2] == 0) begin
      if (a[1:0] == 2'd0) begin m_err = d[15:13]; m_en = d[0]; end
      if (a[1:0] == 2'd3) m_wide = d[0];
    end
  endtask

  task automatic cfg_check(input logic [7:0] a, input string tag);
    @(negedge clk);
    cfg_addr = a; #1;
    chk(32'(cfg_rdata), 32'(m_rd(a)), tag);
  endtask

  task automatic do_acc(input logic [15:0] v, input logic [1:0] m, input logic sp,
                        input logic w, input logic vl, input string tag);
    logic [2:0] r;
    @(negedge clk);
    va = v; cpu_mode = m; is_data = sp; is_write = w; acc_valid = vl;
    #1;
    r = m_why(v, m, sp, w);
    chk(32'(abort), 32'(vl && r != 0), {tag, " abort"});
    if (!(m_en && m == 2'b10)) chk(32'(pa), 32'(m_pa(v, m, sp)), {tag, " pa"});
    @(posedge clk); #1;
    acc_valid = 1'b0;
    if (vl && r != 0) begin
      if (m_err == 0) begin m_info = {w, sp, m, v[15:13]}; m_va = v; end
      m_err = m_err | r;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 2; j++)
        for (int k = 0; k < 8; k++) begin m_par[i][j][k] = 0; m_pdr[i][j][k] = 0; end
    m_err = 0; m_en = 0; m_wide = 0; m_info = 0; m_va = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cfg_check(8'h80, "R1 ctrl0");
    cfg_check(8'h83, "R1 ctrl3");
    cfg_check(8'h75, "R1 descriptor");
    cfg_check(8'h1A, "R1 address reg");
    // R2 relocation off
    do_acc(16'h1234, 2'b11, 1'b1, 1'b1, 1'b1, "R2 low passthrough");
    do_acc(16'hE010, 2'b00, 1'b0, 1'b0, 1'b1, "R2 io page");
    do_acc(16'hDFFF, 2'b10, 1'b0, 1'b0, 1'b1, "R2 below io page");

    // R5 bank selection, R3 wide sum
    cfg_write(8'h83, 16'h0001);
    cfg_write(8'h02, 16'h0100);
    cfg_write(8'h42, 16'h7F03);
    cfg_write(8'h3A, 16'h2000);
    cfg_write(8'h7A, 16'h7F03);
    cfg_write(8'h80, 16'h0001);
    do_acc(16'h4010, 2'b00, 1'b0, 1'b1, 1'b1, "R5 kernel instr");
    do_acc(16'h4010, 2'b11, 1'b1, 1'b1, 1'b1, "R5 user data");
    cfg_write(8'h3A, 16'hFFFF);
    do_acc(16'h5FFF, 2'b11, 1'b1, 1'b0, 1'b1, "R3 wide wrap");
    // R4 narrow
    cfg_write(8'h83, 16'h0000);
    do_acc(16'h5FFF, 2'b11, 1'b1, 1'b0, 1'b1, "R4 narrow wrap");
    cfg_check(8'h80, "R4 no fault");

    // R6 illegal mode
    do_acc(16'h6000, 2'b10, 1'b0, 1'b1, 1'b1, "R6 bad mode");
    cfg_check(8'h80, "R6 flag");
    cfg_check(8'h81, "R9 info");
    cfg_check(8'h82, "R9 va");
    // R7 read-only page, later fault keeps first capture
    cfg_write(8'h1A, 16'h7F01);
    do_acc(16'h4000, 2'b01, 1'b1, 1'b1, 1'b1, "R7 write to read-only");
    cfg_check(8'h80, "R7 flag");
    cfg_check(8'h82, "R9 first fault kept");
    do_acc(16'h4000, 2'b01, 1'b1, 1'b0, 1'b1, "R7 read of read-only");
    do_acc(16'h4000, 2'b01, 1'b1, 1'b1, 1'b0, "R9 invalid no flag");
    cfg_write(8'h80, 16'h0001);
    cfg_check(8'h80, "R9 cleared");

    // R8 downward length
    cfg_write(8'h48, 16'h1000 | 16'h0008 | 16'h0003);
    do_acc(16'h03C0, 2'b00, 1'b1, 1'b0, 1'b1, "R8 down below");
    do_acc(16'h0400, 2'b00, 1'b1, 1'b0, 1'b1, "R8 down at length");
    cfg_check(8'h80, "R8 flag");
    cfg_write(8'h48, 16'h1003);
    do_acc(16'h0440, 2'b00, 1'b1, 1'b0, 1'b1, "R8 up past");
    cfg_write(8'h80, 16'h0001);

    // R10 ignored addresses and masks
    cfg_write(8'h22, 16'hFFFF);
    cfg_check(8'h22, "R10 mode10 reads zero");
    cfg_check(8'h02, "R10 kernel untouched");
    cfg_write(8'h81, 16'hFFFF);
    cfg_check(8'h81, "R10 info read-only");
    cfg_write(8'h84, 16'hFFFF);
    cfg_check(8'h84, "R10 hole");
    cfg_write(8'h80, 16'hFFFF);
    cfg_check(8'h80, "R10 ctrl0 mask");
    cfg_write(8'h80, 16'h0001);
    cfg_write(8'h55, 16'hFFFF);
    cfg_check(8'h55, "R10 descriptor mask");

    // random programming and accesses
    for (int a = 0; a < 128; a++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (a[6] && ($urandom % 4 != 0)) d[1:0] = 2'b11;
      cfg_write(8'(a), d);
    end
    for (int n = 0; n < 600; n++) begin
      logic [1:0] m;
      m = 2'($urandom);
      if (m == 2'b10 && ($urandom % 8 != 0)) m = 2'b11;
      if (n % 150 == 0) cfg_write(8'h83, 16'($urandom % 2));
      do_acc(16'($urandom), m, 1'($urandom), 1'($urandom), 1'($urandom % 3 != 0),
             "R3 R5 R7 R8 random");
      if (n % 16 == 15) begin
        cfg_check(8'h80, "R9 random flags");
        cfg_check(8'h81, "R9 random info");
        cfg_check(8'h82, "R9 random va");
        if ($urandom % 2) cfg_write(8'h80, 16'h0001);
      end
    end
    cfg_write(8'h80, 16'h0000);
    do_acc(16'hF00F, 2'b11, 1'b1, 1'b1, 1'b1, "R2 off again");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule